// File: doc/BRIEF.md
# Prioritized Multi-Function Pin Selector

This block decides, for every pin of a small multi-function pin array, which of several candidate signals drives it. Each pin owns up to five ranked candidate levels and one fallback signal. A level becomes active when at least one of its expressions holds. An expression holds when every one of its field comparisons holds. A comparison takes one source word, keeps only the bits under a mask, shifts the result down to bit 0 and compares it with a fixed value. The source words are a bank of writable configuration registers plus a strap word. The strap word comes from an input port and software cannot change it.

All descriptor tables are fixed at elaboration through two parameters: a descriptor table and an expression-enable table. Every comparison for every pin is evaluated in parallel. Each pin gets a one-hot selection, an encoded level, and a routed output bit taken from its per-level signal inputs. A plain write port with byte enables updates the configuration bank. A read port returns any register, the strap word included. Both ports are plain control pins with no handshake, because configuration traffic is not a stream.

Top module: `pinfunc_mux`

## Requirements
- R1: After reset every configuration register reads back as zero, and the selection follows from zero registers and the current strap input.
- R2: A write to configuration address 0 to 3 updates only the bytes whose byte-enable bit is set (wr_be[b] covers data bits 8b+7..8b). The new value is visible on the read port after the capturing clock edge.
- R3: Address 4 reads the strap input. Writes to address 4 change neither the readback nor any selection.
- R4: A comparison takes the masked field shifted down to bit 0 and compares it with its value. Multi-bit fields must match exactly, and a comparison may require a bit to be 0.
- R5: An expression holds only when all of its comparisons hold.
- R6: A level is active when any of its expressions holds. Several expressions holding at once give the same result as one.
- R7: The selected level is the lowest-numbered active level (level 0 ranks highest). sel_code holds that level number, and sel_onehot has exactly that bit set.
- R8: When no level on a pin is active, the fallback is selected: code 5, one-hot bit 5.
- R9: The selection follows register and strap state with no added latency. A strap change shows without any clock edge.
- R10: pin_out[p] equals sig_in[p*6 + sel_code of pin p].
- R11: A level with no enabled expression is never selected, even when lower levels are active.
- R12: Writes to unmapped addresses 5 to 7 change no register, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data (combinational) |
| strap_in | input | 32 | Read-only strap word |
| sig_in | input | 48 | Candidate signals, 6 per pin (levels 0..4, fallback at index 5) |
| sel_onehot | output | 48 | One-hot selected level, 6 bits per pin |
| sel_code | output | 24 | Encoded selected level, 3 bits per pin |
| pin_out | output | 8 | Routed signal per pin |

## Verification
Checks on every cycle cover three things: exactly one winner per pin, level 0 winning whenever it is active, and the fallback being taken when every level is idle. They also check that the routed bit matches the candidate indexed by the code, that a full-width write lands one cycle later, that unaddressed registers hold their value, and that registers are cleared when reset is released. Whether each pin's expressions decode the right fields can only be shown by the bench's scenarios. These scenarios cover field shifting and multi-bit matches, a bit required to be zero, several expressions holding at once, empty levels, and strap-driven changes, all compared against an independent model of every pin's equations.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int REG_W    = 32;
  localparam int BE_W     = REG_W / 8;
  localparam int NUM_CFG  = 4;
  localparam int SRC_W    = 3;
  localparam int ADDR_W   = $clog2(NUM_CFG + 1) < 3 ? 3 : $clog2(NUM_CFG + 1);
  localparam int NUM_PINS = 8;
  localparam int NUM_LVL  = 5;
  localparam int SEL_W    = NUM_LVL + 1;
  localparam int CODE_W   = $clog2(SEL_W);
  localparam int EXPR_MAX = 3;
  localparam int DESC_MAX = 3;
  localparam int N_EXPR   = NUM_PINS * NUM_LVL * EXPR_MAX;
  localparam int N_DESC   = N_EXPR * DESC_MAX;
  localparam int SRC_WORDS_W = (NUM_CFG + 1) * REG_W;

  typedef struct packed {
    logic             used;
    logic [SRC_W-1:0] src;
    logic [REG_W-1:0] mask;
    logic [REG_W-1:0] val;
  } desc_t;

  typedef desc_t [N_DESC-1:0] desc_tab_t;
  typedef logic  [N_EXPR-1:0] expr_tab_t;

  function automatic int e_idx(int p, int l, int e);
    return (p * NUM_LVL + l) * EXPR_MAX + e;
  endfunction

  function automatic int d_idx(int p, int l, int e, int d);
    return e_idx(p, l, e) * DESC_MAX + d;
  endfunction

  function automatic desc_t mk(int src, int lsb, int width, int val);
    desc_t r;
    r.used = 1'b1;
    r.src  = SRC_W'(src);
    r.mask = ((REG_W'(1) << width) - REG_W'(1)) << lsb;
    r.val  = REG_W'(val);
    return r;
  endfunction

  function automatic int low_bit(logic [REG_W-1:0] m);
    int r;
    r = 0;
    for (int i = REG_W - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  // Source 0..3 are configuration words, source 4 is the strap word.
  function automatic desc_tab_t default_descs();
    desc_tab_t t;
    t = '0;
    t[d_idx(0,0,0,0)] = mk(0, 1, 1, 1);
    t[d_idx(1,0,0,0)] = mk(2, 20, 1, 1);
    t[d_idx(1,1,0,0)] = mk(0, 6, 1, 1);
    t[d_idx(2,0,0,0)] = mk(0, 9, 1, 1);
    t[d_idx(2,0,1,0)] = mk(4, 14, 1, 1);
    t[d_idx(3,0,0,0)] = mk(0, 27, 1, 1);
    t[d_idx(3,1,0,0)] = mk(1, 13, 1, 1);
    t[d_idx(3,1,1,0)] = mk(4, 19, 1, 0);
    t[d_idx(4,0,0,0)] = mk(3, 2, 1, 1);
    t[d_idx(4,0,0,1)] = mk(0, 16, 1, 1);
    t[d_idx(4,0,0,2)] = mk(2, 30, 1, 0);
    t[d_idx(4,1,0,0)] = mk(3, 2, 1, 1);
    t[d_idx(4,1,0,1)] = mk(0, 16, 1, 1);
    t[d_idx(4,1,0,2)] = mk(2, 30, 1, 1);
    for (int e = 0; e < 3; e++) begin
      t[d_idx(5,0,e,0)] = mk(2, 4, 2, e + 1);
      t[d_idx(5,0,e,1)] = mk(1, 18, 1, 1);
    end
    t[d_idx(5,1,0,0)] = mk(1, 18, 1, 1);
    t[d_idx(6,0,0,0)] = mk(2, 4, 2, 3);
    t[d_idx(6,0,0,1)] = mk(1, 21, 1, 1);
    t[d_idx(6,1,0,0)] = mk(1, 21, 1, 1);
    t[d_idx(7,0,0,0)] = mk(3, 8, 1, 1);
    t[d_idx(7,2,0,0)] = mk(3, 10, 1, 1);
    t[d_idx(7,4,0,0)] = mk(3, 11, 2, 2);
    return t;
  endfunction

  function automatic expr_tab_t default_expr_en();
    expr_tab_t x;
    x = '0;
    x[e_idx(0,0,0)] = 1'b1;
    x[e_idx(1,0,0)] = 1'b1;
    x[e_idx(1,1,0)] = 1'b1;
    x[e_idx(2,0,0)] = 1'b1;
    x[e_idx(2,0,1)] = 1'b1;
    x[e_idx(3,0,0)] = 1'b1;
    x[e_idx(3,1,0)] = 1'b1;
    x[e_idx(3,1,1)] = 1'b1;
    x[e_idx(4,0,0)] = 1'b1;
    x[e_idx(4,1,0)] = 1'b1;
    x[e_idx(5,0,0)] = 1'b1;
    x[e_idx(5,0,1)] = 1'b1;
    x[e_idx(5,0,2)] = 1'b1;
    x[e_idx(5,1,0)] = 1'b1;
    x[e_idx(6,0,0)] = 1'b1;
    x[e_idx(6,1,0)] = 1'b1;
    x[e_idx(7,0,0)] = 1'b1;
    x[e_idx(7,2,0)] = 1'b1;
    x[e_idx(7,4,0)] = 1'b1;
    return x;
  endfunction
endpackage

// File: rtl/pmx_regbank.sv
module pmx_regbank
  import pmx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [BE_W-1:0]        wr_be,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [REG_W-1:0]       rd_data,
  input  logic [REG_W-1:0]       strap_in,
  output logic [SRC_WORDS_W-1:0] src_words
);
  logic [REG_W-1:0] cfg_q [NUM_CFG];

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        for (int b = 0; b < BE_W; b++)
          if (wr_be[b]) cfg_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
    assign src_words[i*REG_W +: REG_W] = cfg_q[i];

    // R2: a full-width write lands one cycle later
    a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(i) && (&wr_be)) |=> cfg_q[i] == $past(wr_data));
    // R2: registers not addressed keep their value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(cfg_q[i]));
    // R1: cleared when reset releases
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> cfg_q[i] == '0);
  end

  assign src_words[NUM_CFG*REG_W +: REG_W] = strap_in;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = cfg_q[i];
    if (rd_addr == ADDR_W'(NUM_CFG)) rd_data = strap_in;
  end
endmodule

// File: rtl/pmx_pin_eval.sv
module pmx_pin_eval
  import pmx_pkg::*;
#(
  parameter int        PIN     = 0,
  parameter desc_tab_t DESCS   = default_descs(),
  parameter expr_tab_t EXPR_EN = default_expr_en()
) (
  input  logic [SRC_WORDS_W-1:0] src_words,
  output logic [NUM_LVL-1:0]     lvl_act
);
  logic unused_src;
  assign unused_src = ^src_words;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [EXPR_MAX-1:0] expr_hit;
    for (genvar e = 0; e < EXPR_MAX; e++) begin : g_expr
      logic [DESC_MAX-1:0] d_hit;
      for (genvar d = 0; d < DESC_MAX; d++) begin : g_desc
        localparam desc_t D  = DESCS[d_idx(PIN, l, e, d)];
        localparam int    SH = low_bit(D.mask);
        if (D.used) begin : g_cmp
          logic [REG_W-1:0] word;
          logic [REG_W-1:0] field;
          assign word     = src_words[int'(D.src)*REG_W +: REG_W];
          assign field    = (word & D.mask) >> SH;
          assign d_hit[d] = (field == D.val);
        end else begin : g_none
          assign d_hit[d] = 1'b1;
        end
      end
      assign expr_hit[e] = EXPR_EN[e_idx(PIN, l, e)] & (&d_hit);
    end
    assign lvl_act[l] = |expr_hit;
  end
endmodule

// File: rtl/pmx_prio_pick.sv
module pmx_prio_pick
  import pmx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] lvl_act,
  output logic [SEL_W-1:0]   onehot,
  output logic [CODE_W-1:0]  code
);
  logic blocked;

  always_comb begin
    blocked = 1'b0;
    onehot  = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      onehot[l] = lvl_act[l] & ~blocked;
      blocked   = blocked | lvl_act[l];
    end
    onehot[NUM_LVL] = ~blocked;
  end

  always_comb begin
    code = '0;
    for (int s = 0; s < SEL_W; s++)
      if (onehot[s]) code = CODE_W'(s);
  end

  // R7: exactly one winner per pin
  a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(onehot) == 1);
  // R7: level 0 beats everything
  a_r7_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_act[0] |-> code == '0);
  // R8: fallback when every level is idle
  a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_act == '0) |-> (onehot[NUM_LVL] && code == CODE_W'(NUM_LVL)));
endmodule

// File: rtl/pinfunc_mux.sv
module pinfunc_mux
  import pmx_pkg::*;
#(
  parameter desc_tab_t DESCS   = default_descs(),
  parameter expr_tab_t EXPR_EN = default_expr_en()
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [REG_W-1:0]           wr_data,
  input  logic [BE_W-1:0]            wr_be,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [REG_W-1:0]           rd_data,
  input  logic [REG_W-1:0]           strap_in,
  input  logic [NUM_PINS*SEL_W-1:0]  sig_in,
  output logic [NUM_PINS*SEL_W-1:0]  sel_onehot,
  output logic [NUM_PINS*CODE_W-1:0] sel_code,
  output logic [NUM_PINS-1:0]        pin_out
);
  logic [SRC_WORDS_W-1:0] src_words;

  pmx_regbank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .strap_in  (strap_in),
    .src_words (src_words)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_LVL-1:0] lvl_act;
    logic [SEL_W-1:0]   oh;
    logic [CODE_W-1:0]  cd;

    pmx_pin_eval #(.PIN(p), .DESCS(DESCS), .EXPR_EN(EXPR_EN)) u_eval (
      .src_words (src_words),
      .lvl_act   (lvl_act)
    );

    pmx_prio_pick u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_act (lvl_act),
      .onehot  (oh),
      .code    (cd)
    );

    assign sel_onehot[p*SEL_W +: SEL_W]   = oh;
    assign sel_code[p*CODE_W +: CODE_W]   = cd;
    assign pin_out[p] = |(oh & sig_in[p*SEL_W +: SEL_W]);

    // R10: routed bit is the candidate named by the code
    a_r10_route: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out[p] == sig_in[p*SEL_W + int'(cd)]);
  end
endmodule

// File: tb/pinfunc_mux_tb_top.sv
module pinfunc_mux_tb_top;
  import pmx_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                       rst_n = 1'b0;
  logic                       wr_en = 1'b0;
  logic [ADDR_W-1:0]          wr_addr = '0;
  logic [REG_W-1:0]           wr_data = '0;
  logic [BE_W-1:0]            wr_be = '0;
  logic [ADDR_W-1:0]          rd_addr = '0;
  logic [REG_W-1:0]           rd_data;
  logic [REG_W-1:0]           strap_in = '0;
  logic [NUM_PINS*SEL_W-1:0]  sig_in = '0;
  logic [NUM_PINS*SEL_W-1:0]  sel_onehot;
  logic [NUM_PINS*CODE_W-1:0] sel_code;
  logic [NUM_PINS-1:0]        pin_out;

  pinfunc_mux dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data),
    .strap_in(strap_in), .sig_in(sig_in), .sel_onehot(sel_onehot),
    .sel_code(sel_code), .pin_out(pin_out)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] sh [4];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ref_code(int p);
    logic [4:0]  a;
    logic [31:0] c0, c1, c2, c3, s;
    a = '0; c0 = sh[0]; c1 = sh[1]; c2 = sh[2]; c3 = sh[3]; s = strap_in;
    case (p)
      0: a[0] = c0[1];
      1: begin a[0] = c2[20]; a[1] = c0[6]; end
      2: a[0] = c0[9] | s[14];
      3: begin a[0] = c0[27]; a[1] = c1[13] | ~s[19]; end
      4: begin a[0] = c3[2] & c0[16] & ~c2[30]; a[1] = c3[2] & c0[16] & c2[30]; end
      5: begin a[0] = (c2[5:4] != 2'd0) & c1[18]; a[1] = c1[18]; end
      6: begin a[0] = (c2[5:4] == 2'd3) & c1[21]; a[1] = c1[21]; end
      default: begin a[0] = c3[8]; a[2] = c3[10]; a[4] = (c3[12:11] == 2'd2); end
    endcase
    for (int i = 0; i < 5; i++) if (a[i]) return i;
    return 5;
  endfunction

  function automatic logic [31:0] ref_read(int a);
    if (a < 4) return sh[a];
    if (a == 4) return strap_in;
    return '0;
  endfunction

  task automatic check_pins(string req);
    sig_in = {$urandom, $urandom} & {NUM_PINS*SEL_W{1'b1}};
    #1;
    for (int p = 0; p < NUM_PINS; p++) begin
      int ex;
      ex = ref_code(p);
      check(req, $sformatf("pin%0d code", p), 32'(sel_code[p*CODE_W +: CODE_W]), 32'(ex));
      check(req, $sformatf("pin%0d onehot", p), 32'(sel_onehot[p*SEL_W +: SEL_W]), 32'(1) << ex);
      check("R10", $sformatf("pin%0d route", p), 32'(pin_out[p]), 32'(sig_in[p*SEL_W + ex]));
    end
  endtask

  task automatic check_read(string req, int a);
    rd_addr = ADDR_W'(a);
    #1;
    check(req, $sformatf("readback addr %0d", a), rd_data, ref_read(a));
  endtask

  task automatic wr(int a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 4)
      for (int b = 0; b < 4; b++) if (be[b]) sh[a][b*8 +: 8] = d[b*8 +: 8];
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) check_read("R1", a);
    check_pins("R1");

    // R2: partial byte write
    wr(0, 32'hAABBCCDD, 4'b0101);
    check_read("R2", 0);
    wr(0, 32'h11223344, 4'b1010);
    check_read("R2", 0);
    wr(0, 32'h0, 4'hF);

    // R3: strap address is read-only
    @(negedge clk); strap_in = 32'h0008_0000;
    wr(4, 32'hFFFF_FFFF, 4'hF);
    check_read("R3", 4);
    check_pins("R3");

    // R12: unmapped addresses
    wr(6, 32'hFFFF_FFFF, 4'hF);
    for (int a = 0; a < 8; a++) check_read("R12", a);

    // R9: strap change without clock edge
    @(negedge clk); #2; strap_in = 32'h0000_4000;
    check_pins("R9");
    strap_in = 32'h0;
    check_pins("R9");

    // R4 / R6: multi-bit mode field and several expressions
    wr(1, 32'h0024_0000, 4'hF);
    for (int m = 0; m < 4; m++) begin
      wr(2, 32'(m) << 4, 4'hF);
      check_pins("R6");
    end

    // R4 / R5: zero-required bit and AND of three comparisons
    wr(3, 32'h4, 4'hF);
    wr(0, 32'h1_0000, 4'hF);
    check_pins("R5");
    wr(2, 32'h4000_0000, 4'hF);
    check_pins("R4");
    wr(0, 32'h0, 4'hF);
    check_pins("R5");

    // R11: empty levels on pin 7
    wr(3, 32'h0000_1000, 4'hF);
    check_pins("R11");
    wr(3, 32'h0000_1800, 4'hF);
    check_pins("R11");
    wr(3, 32'h0000_1400, 4'hF);
    check_pins("R11");

    // R7 / R8: random sweep
    for (int it = 0; it < 400; it++) begin
      int a;
      a = ($urandom % 8 < 6) ? int'($urandom % 4) : int'($urandom % 8);
      if ($urandom % 5 == 0) begin
        @(negedge clk);
        strap_in = $urandom;
      end
      wr(a, $urandom, 4'($urandom));
      check_read("R2", a);
      check_pins((it % 2) ? "R7" : "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule